// File: doc/BRIEF.md
# Character Display Parallel Bus Sequencer

This block sits on the host side of an asynchronous parallel bus that connects to a character-display device. The bus has an active-low chip select, separate active-low write and read strobes, an address, 8-bit data and an active-low device reset. A client hands the block one access at a time through a valid/ready port. The block then runs the bus cycle. Every setup, active, hold and recovery interval is stretched to a whole number of system-clock cycles, and each interval covers a minimum time given in nanoseconds.

Every interval length comes from a nanosecond parameter and the clock-period parameter. The count is computed when the block is elaborated: the time divided by the period, rounded up, and never less than one cycle. Write and read windows have separate lengths. On reset, the block drives a device reset pulse. It then keeps the request port closed for a long settling wait. A read ends with a one-cycle completion pulse that carries the captured byte. A build option targets write-only hookups. In that build, the read strobe is held inactive, the write strobe is the chip-select waveform itself, and every request runs as a write.

Top module: `dispbus_ctrl`

## Requirements
- R1: While `rst_n` is low: `bus_rst_n`=0, `bus_ce_n`=`bus_wr_n`=`bus_rd_n`=1, `bus_doe`=0, `req_ready`=0 and `rd_done`=0.
- R2: After `rst_n` is released, `bus_rst_n` stays low until the RC-th rising clock edge, then goes high. RC = ceil(T_RST_NS / CLK_PERIOD_NS).
- R3: `req_ready` goes high only from clock edge RC+WT after release, where WT = ceil(T_RST_WAIT_NS / CLK_PERIOD_NS). It is high only while no access is in progress. A request is accepted on an edge where `req_valid` and `req_ready` are both high.
- R4: `bus_addr` takes the request address on the accepting edge. Chip select falls ACS cycles later, with ACS = ceil(T_ACS_NS / period). The address then stays unchanged while chip select is low and for HLD cycles after chip select rises.
- R5: A write (`req_write`=1) holds `bus_ce_n` and `bus_wr_n` low together for exactly ACTW cycles. ACTW is the largest of ceil(140/period), ceil(100/period) and ceil(50/period), taken over the chip-select, strobe and data-setup minimums.
- R6: A read (`req_write`=0) holds `bus_ce_n` and `bus_rd_n` low for exactly ACTR cycles. ACTR is the larger of ceil(160/period) and ceil(75/period). `bus_din` is sampled on the edge that ends the window. `rd_done` is high for that single cycle, with the sampled byte on `rd_data`.
- R7: `bus_doe` is high from the accepting edge of a write until its hold phase ends. It is low throughout reads, recovery and idle.
- R8: After the hold phase (HLD cycles: ceil(max(20,20)/period) for writes, ceil(max(20,10)/period) for reads), a recovery phase of REC = ceil(60/period) cycles follows. `req_ready` returns on the edge that ends recovery.
- R9: During a write, `bus_dout` equals the request data from the accepting edge through the end of the hold phase. This covers the strobe's rising edge with setup and hold margin.
- R10: With WRITE_ONLY=1, `bus_rd_n` is constantly 1 and `bus_wr_n` always equals `bus_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Byte to write |
| rd_done | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Byte captured by the read |
| bus_rst_n | output | 1 | Device reset, active low |
| bus_ce_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Data driven toward the device |
| bus_doe | output | 1 | Output enable for the data pins |
| bus_din | input | DATA_W | Data returned by the device |

## Verification
The bound checker watches the invariants that hold on every clock:
- the strobes never overlap and only appear under chip select;
- the address never moves while chip select is low or on the cycle it rises;
- the data pins are never enabled under a read strobe;
- the write byte stays steady while enabled;
- chip select has a minimum high time before each fall;
- the completion pulse is single-cycle;
- the request port stays closed during device reset;
- the write-only tie holds in that build.

Exact window lengths, the full lockout duration, the read sampling edge and whether the returned bytes are correct need the bench scenarios. Its behavioural device model returns corrupted data until the read has been active long enough. A reset arrives in the middle of a read, and requests are held during the lockout.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_HOLD,
      PH_RECOV
   } bus_phase_e;

   typedef enum logic [1:0] {
      RS_PULSE,
      RS_WAIT,
      RS_OPEN
   } rst_stage_e;

   // whole clock cycles covering a minimum time, never zero
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned period_ns);
      int unsigned c;
      c = (ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dispbus_timer.sv
module dispbus_timer #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned INIT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(INIT);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/dispbus_rst_seq.sv
module dispbus_rst_seq
   import dispbus_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PULSE_CYC = 75,
   parameter int unsigned WAIT_CYC  = 27500
) (
   input  logic clk,
   input  logic rst_n,
   output logic bus_rst_n,
   output logic open_q
);

   localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'(WAIT_CYC - 1);

   rst_stage_e stage_q;
   logic       t_load;
   logic       t_exp;

   assign t_load = (stage_q == RS_PULSE) && t_exp;

   dispbus_timer #(
      .CNT_W (CNT_W),
      .INIT  (PULSE_CYC - 1)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (WAIT_LD),
      .expired  (t_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q   <= RS_PULSE;
         bus_rst_n <= 1'b0;
         open_q    <= 1'b0;
      end else begin
         case (stage_q)
            RS_PULSE: if (t_exp) begin
               stage_q   <= RS_WAIT;
               bus_rst_n <= 1'b1;
            end
            RS_WAIT: if (t_exp) begin
               stage_q <= RS_OPEN;
               open_q  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dispbus_cycle_fsm.sv
module dispbus_cycle_fsm
   import dispbus_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned ACS_CYC    = 3,
   parameter int unsigned ACT_WR_CYC = 35,
   parameter int unsigned ACT_RD_CYC = 40,
   parameter int unsigned HLD_WR_CYC = 5,
   parameter int unsigned HLD_RD_CYC = 5,
   parameter int unsigned REC_CYC    = 15,
   parameter bit          WRITE_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_q,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_data,
   output logic              ce_n,
   output logic              wr_n,
   output logic              rd_n,
   output logic              doe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   input  logic [DATA_W-1:0] bus_din
);

   localparam logic [CNT_W-1:0] ACS_LD  = CNT_W'(ACS_CYC - 1);
   localparam logic [CNT_W-1:0] ACTW_LD = CNT_W'(ACT_WR_CYC - 1);
   localparam logic [CNT_W-1:0] ACTR_LD = CNT_W'(ACT_RD_CYC - 1);
   localparam logic [CNT_W-1:0] HLDW_LD = CNT_W'(HLD_WR_CYC - 1);
   localparam logic [CNT_W-1:0] HLDR_LD = CNT_W'(HLD_RD_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_CYC - 1);

   bus_phase_e       phase_q;
   logic             is_wr_q;
   logic             kind_wr;
   logic             accept;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             t_exp;

   generate
      if (WRITE_ONLY) begin : g_kind_wo
         assign kind_wr = 1'b1;
      end else begin : g_kind_rw
         assign kind_wr = req_write;
      end
   endgenerate

   assign req_ready = (phase_q == PH_IDLE) && open_q;
   assign accept    = req_valid && req_ready;

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      case (phase_q)
         PH_IDLE: if (accept) begin
            t_load = 1'b1;
            t_val  = ACS_LD;
         end
         PH_SETUP: if (t_exp) begin
            t_load = 1'b1;
            t_val  = is_wr_q ? ACTW_LD : ACTR_LD;
         end
         PH_ACTIVE: if (t_exp) begin
            t_load = 1'b1;
            t_val  = is_wr_q ? HLDW_LD : HLDR_LD;
         end
         PH_HOLD: if (t_exp) begin
            t_load = 1'b1;
            t_val  = REC_LD;
         end
         default: ;
      endcase
   end

   dispbus_timer #(
      .CNT_W (CNT_W),
      .INIT  (0)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         is_wr_q  <= 1'b0;
         ce_n     <= 1'b1;
         wr_n     <= 1'b1;
         rd_n     <= 1'b1;
         doe      <= 1'b0;
         bus_addr <= '0;
         bus_dout <= '0;
         rd_done  <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_done <= 1'b0;
         case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q  <= PH_SETUP;
               is_wr_q  <= kind_wr;
               bus_addr <= req_addr;
               bus_dout <= req_wdata;
               doe      <= kind_wr;
            end
            PH_SETUP: if (t_exp) begin
               phase_q <= PH_ACTIVE;
               ce_n    <= 1'b0;
               if (is_wr_q) wr_n <= 1'b0;
               else         rd_n <= 1'b0;
            end
            PH_ACTIVE: if (t_exp) begin
               phase_q <= PH_HOLD;
               ce_n    <= 1'b1;
               wr_n    <= 1'b1;
               rd_n    <= 1'b1;
               if (!is_wr_q) begin
                  rd_done <= 1'b1;
                  rd_data <= bus_din;
               end
            end
            PH_HOLD: if (t_exp) begin
               phase_q <= PH_RECOV;
               doe     <= 1'b0;
            end
            PH_RECOV: if (t_exp) begin
               phase_q <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dispbus_ctrl.sv
module dispbus_ctrl
   import dispbus_pkg::*;
#(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned T_ACS_NS      = 10,
   parameter int unsigned T_ACH_NS      = 20,
   parameter int unsigned T_CE_WR_NS    = 140,
   parameter int unsigned T_CE_RD_NS    = 160,
   parameter int unsigned T_CER_NS      = 60,
   parameter int unsigned T_WR_NS       = 100,
   parameter int unsigned T_WSU_NS      = 50,
   parameter int unsigned T_WH_NS       = 20,
   parameter int unsigned T_RDV_NS      = 75,
   parameter int unsigned T_DF_NS       = 10,
   parameter int unsigned T_RST_NS      = 300,
   parameter int unsigned T_RST_WAIT_NS = 110000,
   parameter bit          WRITE_ONLY    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_data,
   output logic              bus_rst_n,
   output logic              bus_ce_n,
   output logic              bus_wr_n,
   output logic              bus_rd_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din
);

   localparam int unsigned ACS_CYC    = ns_to_cycles(T_ACS_NS, CLK_PERIOD_NS);
   localparam int unsigned ACT_WR_CYC = max_u(ns_to_cycles(T_CE_WR_NS, CLK_PERIOD_NS),
                                        max_u(ns_to_cycles(T_WR_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_WSU_NS, CLK_PERIOD_NS)));
   localparam int unsigned ACT_RD_CYC = max_u(ns_to_cycles(T_CE_RD_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_RDV_NS, CLK_PERIOD_NS));
   localparam int unsigned HLD_WR_CYC = max_u(ns_to_cycles(T_ACH_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_WH_NS, CLK_PERIOD_NS));
   localparam int unsigned HLD_RD_CYC = max_u(ns_to_cycles(T_ACH_NS, CLK_PERIOD_NS),
                                              ns_to_cycles(T_DF_NS, CLK_PERIOD_NS));
   localparam int unsigned REC_CYC    = ns_to_cycles(T_CER_NS, CLK_PERIOD_NS);
   localparam int unsigned RST_CYC    = ns_to_cycles(T_RST_NS, CLK_PERIOD_NS);
   localparam int unsigned WAIT_CYC   = ns_to_cycles(T_RST_WAIT_NS, CLK_PERIOD_NS);
   localparam int unsigned LONGEST    = max_u(max_u(WAIT_CYC, RST_CYC),
                                        max_u(max_u(ACT_WR_CYC, ACT_RD_CYC),
                                        max_u(REC_CYC, max_u(HLD_WR_CYC, HLD_RD_CYC))));
   localparam int unsigned CNT_W      = $clog2(LONGEST + 1);

   generate
      if (CLK_PERIOD_NS == 0) begin : g_bad_period
         $error("CLK_PERIOD_NS must be nonzero");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   logic open_q;
   logic ce_n_q;
   logic wr_n_q;
   logic rd_n_q;

   dispbus_rst_seq #(
      .CNT_W     (CNT_W),
      .PULSE_CYC (RST_CYC),
      .WAIT_CYC  (WAIT_CYC)
   ) u_rst_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst_n (bus_rst_n),
      .open_q    (open_q)
   );

   dispbus_cycle_fsm #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .ACS_CYC    (ACS_CYC),
      .ACT_WR_CYC (ACT_WR_CYC),
      .ACT_RD_CYC (ACT_RD_CYC),
      .HLD_WR_CYC (HLD_WR_CYC),
      .HLD_RD_CYC (HLD_RD_CYC),
      .REC_CYC    (REC_CYC),
      .WRITE_ONLY (WRITE_ONLY)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_q    (open_q),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_done   (rd_done),
      .rd_data   (rd_data),
      .ce_n      (ce_n_q),
      .wr_n      (wr_n_q),
      .rd_n      (rd_n_q),
      .doe       (bus_doe),
      .bus_addr  (bus_addr),
      .bus_dout  (bus_dout),
      .bus_din   (bus_din)
   );

   assign bus_ce_n = ce_n_q;

   generate
      if (WRITE_ONLY) begin : g_strobe_wo
         assign bus_wr_n = ce_n_q;
         assign bus_rd_n = 1'b1;
      end else begin : g_strobe_rw
         assign bus_wr_n = wr_n_q;
         assign bus_rd_n = rd_n_q;
      end
   endgenerate

endmodule

// File: rtl/dispbus_ctrl_chk.sv
module dispbus_ctrl_chk
   import dispbus_pkg::*;
#(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned T_CER_NS      = 60,
   parameter bit          WRITE_ONLY    = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rd_done,
   input logic              bus_rst_n,
   input logic              bus_ce_n,
   input logic              bus_wr_n,
   input logic              bus_rd_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_doe
);

   localparam int unsigned CER_CYC = ns_to_cycles(T_CER_NS, CLK_PERIOD_NS);

   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               hi_cnt <= CER_CYC;
      else if (!bus_ce_n)       hi_cnt <= 0;
      else if (hi_cnt < CER_CYC) hi_cnt <= hi_cnt + 1;
   end

   p_closed_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rst_n |-> (bus_ce_n && !req_ready));

   p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_ce_n && bus_wr_n && bus_rd_n && !bus_doe));

   p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n || $past(!bus_ce_n)) |-> $stable(bus_addr));

   p_wr_under_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !bus_ce_n);

   p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> bus_wr_n);

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   p_done_at_rd_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $rose(bus_rd_n));

   p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_doe);

   p_ce_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ce_n) |-> (hi_cnt >= CER_CYC));

   p_dout_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

   generate
      if (WRITE_ONLY) begin : g_wo_chk
         p_wo_tie_r10: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd_n && (bus_wr_n == bus_ce_n));
      end
   endgenerate

endmodule

bind dispbus_ctrl dispbus_ctrl_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .T_CER_NS      (T_CER_NS),
   .WRITE_ONLY    (WRITE_ONLY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rd_done   (rd_done),
   .bus_rst_n (bus_rst_n),
   .bus_ce_n  (bus_ce_n),
   .bus_wr_n  (bus_wr_n),
   .bus_rd_n  (bus_rd_n),
   .bus_addr  (bus_addr),
   .bus_dout  (bus_dout),
   .bus_doe   (bus_doe)
);

// File: tb/dispbus_ctrl_tb.sv
`timescale 1ns/1ps
module dispbus_ctrl_tb;

   localparam int PER = 4;
   localparam int AW  = 5;
   localparam int DW  = 8;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int ACS  = cdiv(10);
   localparam int ACTW = cdiv(140);
   localparam int ACTR = cdiv(160);
   localparam int HLDW = cdiv(20);
   localparam int HLDR = cdiv(20);
   localparam int REC  = cdiv(60);
   localparam int RC   = cdiv(300);
   localparam int WT   = cdiv(110000);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_write;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic [DW-1:0] bus_din;

   logic          req_ready, rd_done, bus_rst_n, bus_ce_n, bus_wr_n, bus_rd_n, bus_doe;
   logic [DW-1:0] rd_data, bus_dout;
   logic [AW-1:0] bus_addr;

   logic          wo_ready, wo_done, wo_rst_n, wo_ce_n, wo_wr_n, wo_rd_n, wo_doe;
   logic [DW-1:0] wo_rdata, wo_dout;
   logic [AW-1:0] wo_addr;

   always #2 clk = ~clk;

   dispbus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_done(rd_done), .rd_data(rd_data), .bus_rst_n(bus_rst_n),
      .bus_ce_n(bus_ce_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din));

   dispbus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER), .WRITE_ONLY(1'b1)) u_wo (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(wo_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_done(wo_done), .rd_data(wo_rdata), .bus_rst_n(wo_rst_n),
      .bus_ce_n(wo_ce_n), .bus_wr_n(wo_wr_n), .bus_rd_n(wo_rd_n),
      .bus_addr(wo_addr), .bus_dout(wo_dout), .bus_doe(wo_doe), .bus_din('0));

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   logic [DW-1:0] ref_mem [2**AW];
   logic [DW-1:0] dev_mem [2**AW];

   // reference model state
   int            n = 0;
   bit            busy = 1'b0;
   int            k = 0;
   bit            cur_wr = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   logic [DW-1:0] cur_data = '0;

   int            rdcnt = 0;
   logic          prev_wr_n = 1'b1;

   function automatic int act_len(input bit w);
      return w ? ACTW : ACTR;
   endfunction
   function automatic int hld_len(input bit w);
      return w ? HLDW : HLDR;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         n    = 0;
         busy = 1'b0;
      end else begin
         if (busy) begin
            k++;
            if (k >= ACS + act_len(cur_wr) + hld_len(cur_wr) + REC) busy = 1'b0;
         end else if (n >= RC + WT && req_valid) begin
            busy     = 1'b1;
            k        = 0;
            cur_wr   = req_write;
            cur_addr = req_addr;
            cur_data = req_wdata;
            if (req_write) ref_mem[req_addr] = req_wdata;
         end
         if (n < 1000000) n++;
      end
   end

   always @(negedge clk) begin
      bit  e_rst, e_ready, ce_low, e_ce, e_wr, e_rd, e_doe, e_done, in_win;
      // behavioural device on the bus
      if (!bus_ce_n && !bus_rd_n) rdcnt++;
      else                        rdcnt = 0;
      if (!prev_wr_n && bus_wr_n) dev_mem[bus_addr] = bus_dout;
      prev_wr_n = bus_wr_n;
      bus_din = (rdcnt >= ACTR) ? dev_mem[bus_addr] : ~dev_mem[bus_addr];

      if (!rst_n) begin
         e_rst = 0; e_ready = 0; ce_low = 0; e_doe = 0; e_done = 0; in_win = 0;
         e_wr = 1; e_rd = 1;
      end else begin
         e_rst   = (n >= RC);
         e_ready = !busy && (n >= RC + WT);
         ce_low  = busy && k >= ACS && k < ACS + act_len(cur_wr);
         e_wr    = !(ce_low && cur_wr);
         e_rd    = !(ce_low && !cur_wr);
         in_win  = busy && k < ACS + act_len(cur_wr) + hld_len(cur_wr);
         e_doe   = in_win && cur_wr;
         e_done  = busy && !cur_wr && k == ACS + ACTR;
      end
      e_ce = !ce_low;
      if (!rst_n) begin
         chk(bus_rst_n == 0 && bus_ce_n && bus_wr_n && bus_rd_n && !bus_doe
             && !req_ready && !rd_done, "R1 reset outputs",
             {bus_rst_n, bus_ce_n, bus_wr_n, bus_rd_n, bus_doe, req_ready, rd_done},
             7'b0111000);
      end else begin
         chk(bus_rst_n == e_rst, "R2 bus_rst_n", bus_rst_n, e_rst);
         chk(req_ready == e_ready, "R3 req_ready", req_ready, e_ready);
         chk(bus_ce_n == e_ce, "R8 bus_ce_n timing", bus_ce_n, e_ce);
         chk(bus_wr_n == e_wr, "R5 bus_wr_n", bus_wr_n, e_wr);
         chk(bus_rd_n == e_rd, "R6 bus_rd_n", bus_rd_n, e_rd);
         chk(bus_doe == e_doe, "R7 bus_doe", bus_doe, e_doe);
         chk(rd_done == e_done, "R6 rd_done", rd_done, e_done);
         if (in_win) chk(bus_addr == cur_addr, "R4 bus_addr", bus_addr, cur_addr);
         if (e_doe)  chk(bus_dout == cur_data, "R9 bus_dout", bus_dout, cur_data);
         if (e_done) chk(rd_data == ref_mem[cur_addr], "R6 rd_data",
                         rd_data, ref_mem[cur_addr]);
      end
      chk(wo_rd_n == 1'b1, "R10 rd strobe tied", wo_rd_n, 1);
      chk(wo_wr_n == wo_ce_n, "R10 wr equals ce", wo_wr_n, wo_ce_n);
   end

   task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 2**AW; i++) begin
         ref_mem[i] = 8'(i * 7 + 3);
         dev_mem[i] = 8'(i * 7 + 3);
      end
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      bus_din   = '0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R3: request held through the whole lockout
      do_req(1'b0, 5'd3, 8'h00);
      // back-to-back writes, edge addresses and data (R5, R9)
      do_req(1'b1, 5'd5,  8'h3C);
      do_req(1'b1, 5'd0,  8'hFF);
      do_req(1'b1, 5'd31, 8'h00);
      repeat (7) @(negedge clk);
      // read back (R6)
      do_req(1'b0, 5'd5,  8'h00);
      do_req(1'b0, 5'd31, 8'h00);
      do_req(1'b0, 5'd0,  8'h00);
      repeat (2) @(negedge clk);
      do_req(1'b1, 5'd5,  8'hA5);
      do_req(1'b0, 5'd5,  8'h00);
      do_req(1'b0, 5'd17, 8'h00);
      // R1: reset arriving in the middle of a read
      do_req(1'b0, 5'd12, 8'h00);
      repeat (20) @(posedge clk);
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      do_req(1'b1, 5'd9, 8'h77);
      do_req(1'b0, 5'd9, 8'h00);
      do_req(1'b0, 5'd12, 8'h00);
      repeat (80) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual=timeout expected=completion");
         finish_run();
      end
   end

endmodule